// File: doc/BRIEF.md
# Indexed and Indirect Address Former for an 8-bit Core

This unit computes the 16-bit operand address for one instruction of an 8-bit core with a 16-bit address space. The core presents the addressing-mode code, the one or two operand bytes that follow the opcode, and the current X and Y index values, and pulses a request. Direct forms need no memory access, so the unit returns their address one cycle after the request. Pointer forms read two bytes over a single-cycle synchronous read port first. These are zero-page indirect, pre-indexed indirect, post-indexed indirect, jump indirect and jump indirect indexed. The unit then adds any post-index and returns the final address.

Along with the address, the unit reports the base cycle count of the instruction that uses this mode. Stores pay an extra cycle on absolute indexed and on indirect forms. Page zero is a closed 256-byte ring for indexing and for pointer bytes. A jump pointer whose low byte sits at the last byte of a page takes its high byte from the first byte of the same page.

Top module: `addr_former`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, idle_o is 1, done_o is 0 and mem_re_o is 0.
- R2: mode_i codes are 0 immediate, 1 zero page, 2 zero page +X, 3 zero page +Y, 4 absolute, 5 absolute +X, 6 absolute +Y, 7 zero-page indirect, 8 pre-indexed (zp+X) indirect, 9 post-indexed indirect +Y, 10 jump indirect, 11 jump indirect +X. Codes 12 to 15 act as immediate. For immediate, addr_o is {8'h00, op_lo_i}. For zero page it is {8'h00, op_lo_i} and for absolute it is {op_hi_i, op_lo_i}. Direct modes (0 to 6) raise done_o in the cycle right after the accepting edge.
- R3: Zero page indexed forms give {8'h00, (op_lo_i + index) mod 256}.
- R4: Absolute indexed forms give ({op_hi_i, op_lo_i} + index) mod 65536, carrying into the high byte.
- R5: A pointer form asserts mem_re_o for two consecutive cycles, starting the cycle after acceptance. The first cycle reads the pointer low byte and the second reads the high byte at the low address with only its low byte incremented. mem_rdata_i is taken in the cycle after each read. done_o rises four cycles after the accepting edge. Zero-page indirect reads {00,op_lo} and {00,op_lo+1 mod 256}, and returns the pointer.
- R6: Pre-indexed indirect reads its pointer at {00,(op_lo_i+X) mod 256} and the following zero-page byte, wrapping $FF to $00.
- R7: Post-indexed indirect fetches the pointer as in R5, and then returns (pointer + Y) mod 65536.
- R8: Jump indirect reads {op_hi_i,op_lo_i}, then {op_hi_i,op_lo_i+1 mod 256}. A pointer at $xxFF takes its high byte from $xx00.
- R9: Jump indirect indexed forms base = {op_hi_i,op_lo_i}+X with a 16-bit carry. It reads base, then {base[15:8], base[7:0]+1 mod 256}, and returns the pointer.
- R10: cycles_o, valid while done_o is 1, is 2 for immediate and reserved codes and 3 for zero page. It is 4 for zero page indexed, absolute and absolute indexed, and 5 for zero-page indirect, post-indexed indirect and jump indirect. It is 6 for pre-indexed indirect and jump indirect indexed.
- R11: With store_i set, absolute indexed reports 5 and the three data indirect forms (7, 8, 9) report 6. The other modes report their R10 count.
- R12: done_o is a one-cycle pulse. A request is accepted only when idle_o is 1, and a request while busy has no effect on the result or the reads. done_o stays 0 while a pointer fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken when idle |
| mode_i | input | 4 | Addressing-mode code |
| store_i | input | 1 | Instruction writes memory |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| idle_o | output | 1 | Ready for a request |
| mem_re_o | output | 1 | Read enable |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_re_o |
| done_o | output | 1 | Result valid pulse |
| addr_o | output | 16 | Effective address |
| cycles_o | output | 4 | Base instruction cycle count |

## Verification
The assertions assume that the memory port returns data exactly one cycle after each read. They also assume that the core keeps mode, operands and indices stable only at the accepting edge and nowhere else. The address-step checks further rely on the high-byte read always directly following the low-byte read. The bench models memory as a registered read of a fixed function of the address, so it honours the one-cycle latency. It changes inputs only on falling edges, and it deliberately fires a second request mid-fetch to show that it is dropped.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_ZP    = 4'd1,
    AM_ZPX   = 4'd2,
    AM_ZPY   = 4'd3,
    AM_ABS   = 4'd4,
    AM_ABSX  = 4'd5,
    AM_ABSY  = 4'd6,
    AM_ZIND  = 4'd7,
    AM_XIND  = 4'd8,
    AM_INDY  = 4'd9,
    AM_JIND  = 4'd10,
    AM_JINDX = 4'd11
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_CAP, ST_FIN
  } agu_state_e;

  function automatic logic is_ptr(input logic [3:0] m);
    return (m >= 4'd7) && (m <= 4'd11);
  endfunction
endpackage

// File: rtl/agu_cost.sv
module agu_cost
  import agu_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [3:0]    mode_i,
  input  logic          store_i,
  output logic [CW-1:0] cycles_o
);
  always_comb begin
    case (mode_i)
      AM_ZP:                      cycles_o = CW'(3);
      AM_ZPX, AM_ZPY, AM_ABS:     cycles_o = CW'(4);
      AM_ABSX, AM_ABSY:           cycles_o = store_i ? CW'(5) : CW'(4);
      AM_ZIND, AM_INDY:           cycles_o = store_i ? CW'(6) : CW'(5);
      AM_XIND:                    cycles_o = CW'(6);
      AM_JIND:                    cycles_o = CW'(5);
      AM_JINDX:                   cycles_o = CW'(6);
      default:                    cycles_o = CW'(2);
    endcase
  end
endmodule

// File: rtl/agu_direct.sv
module agu_direct
  import agu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [AW-1:0] addr_o
);
  logic [DW-1:0] idx;
  logic [DW-1:0] zp_sum;
  logic [AW-1:0] abs_sum;

  assign idx     = (mode_i == AM_ZPY || mode_i == AM_ABSY) ? y_i : x_i;
  assign zp_sum  = op_lo_i + idx;
  assign abs_sum = {op_hi_i, op_lo_i} + {{DW{1'b0}}, idx};

  always_comb begin
    case (mode_i)
      AM_ZPX, AM_ZPY:   addr_o = {{DW{1'b0}}, zp_sum};
      AM_ABS:           addr_o = {op_hi_i, op_lo_i};
      AM_ABSX, AM_ABSY: addr_o = abs_sum;
      default:          addr_o = {{DW{1'b0}}, op_lo_i};
    endcase
  end
endmodule

// File: rtl/agu_ptr_base.sv
module agu_ptr_base
  import agu_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  output logic [AW-1:0] lo_addr_o,
  output logic [AW-1:0] hi_addr_o
);
  logic [AW-1:0] base;
  logic [DW-1:0] zx;

  assign zx = op_lo_i + x_i;

  always_comb begin
    case (mode_i)
      AM_XIND:  base = {{DW{1'b0}}, zx};
      AM_JIND:  base = {op_hi_i, op_lo_i};
      AM_JINDX: base = {op_hi_i, op_lo_i} + {{DW{1'b0}}, x_i};
      default:  base = {{DW{1'b0}}, op_lo_i};
    endcase
  end

  // high byte pointer never leaves the page of the low byte
  assign lo_addr_o = base;
  assign hi_addr_o = {base[AW-1:DW], base[DW-1:0] + DW'(1)};
endmodule

// File: rtl/addr_former.sv
module addr_former
  import agu_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [3:0]    mode_i,
  input  logic          store_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          idle_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cycles_o
);
  agu_state_e    state_q;
  logic [AW-1:0] lo_a_q, hi_a_q, res_q;
  logic [DW-1:0] ptr_lo_q, y_q;
  logic          post_q;
  logic [CW-1:0] cyc_q;

  logic [CW-1:0] cost;
  logic [AW-1:0] dir_addr, lo_a, hi_a;

  agu_cost #(.CW(CW)) u_cost (
    .mode_i(mode_i), .store_i(store_i), .cycles_o(cost)
  );

  agu_direct #(.DW(DW)) u_dir (
    .mode_i(mode_i), .op_lo_i(op_lo_i), .op_hi_i(op_hi_i),
    .x_i(x_i), .y_i(y_i), .addr_o(dir_addr)
  );

  agu_ptr_base #(.DW(DW)) u_ptr (
    .mode_i(mode_i), .op_lo_i(op_lo_i), .op_hi_i(op_hi_i),
    .x_i(x_i), .lo_addr_o(lo_a), .hi_addr_o(hi_a)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lo_a_q   <= '0;
      hi_a_q   <= '0;
      res_q    <= '0;
      ptr_lo_q <= '0;
      y_q      <= '0;
      post_q   <= 1'b0;
      cyc_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          cyc_q <= cost;
          if (is_ptr(mode_i)) begin
            lo_a_q  <= lo_a;
            hi_a_q  <= hi_a;
            y_q     <= y_i;
            post_q  <= (mode_i == AM_INDY);
            state_q <= ST_LO;
          end else begin
            res_q   <= dir_addr;
            state_q <= ST_FIN;
          end
        end
        ST_LO:  state_q <= ST_HI;
        ST_HI: begin
          ptr_lo_q <= mem_rdata_i;  // low byte returns during high read
          state_q  <= ST_CAP;
        end
        ST_CAP: begin
          res_q   <= {mem_rdata_i, ptr_lo_q} + (post_q ? {{DW{1'b0}}, y_q} : '0);
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign mem_re_o   = (state_q == ST_LO) || (state_q == ST_HI);
  assign mem_addr_o = (state_q == ST_HI) ? hi_a_q : lo_a_q;
  assign done_o     = (state_q == ST_FIN);
  assign addr_o     = res_q;
  assign cycles_o   = cyc_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_NO_READ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_re_o); // R12
  AST_READS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !$past(mem_re_o) && !idle_o) |=> mem_re_o); // R5
  AST_HI_NEXT_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HI) |-> mem_addr_o[DW-1:0] == ($past(mem_addr_o[DW-1:0]) + DW'(1))); // R5
  AST_HI_SAME_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HI) |-> mem_addr_o[AW-1:DW] == $past(mem_addr_o[AW-1:DW])); // R8
  AST_CYCLES_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o >= CW'(2) && cycles_o <= CW'(6))); // R10
endmodule

// File: tb/sim_addr_former.sv
module sim_addr_former;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic        store_i = 1'b0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, x_i = '0, y_i = '0;
  logic        idle_o, mem_re_o, done_o;
  logic [15:0] mem_addr_o, addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [3:0]  cycles_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] rd_log [16];
  int rd_n = 0;

  always #2 clk_i = ~clk_i;

  addr_former u0 (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hC5;
  endfunction

  always @(posedge clk_i) begin
    if (mem_re_o) begin
      mem_rdata_i   <= memf(mem_addr_o);
      rd_log[rd_n % 16] <= mem_addr_o;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  logic [15:0] r_addr;
  logic [3:0]  r_cyc;
  int          r_lat;
  int          r_base;

  task automatic run(input logic [3:0] m, input logic st, input logic [7:0] lo,
                     input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk_i);
    r_base = rd_n;
    req_i = 1'b1; mode_i = m; store_i = st; op_lo_i = lo; op_hi_i = hi; x_i = x; y_i = y;
    @(negedge clk_i);
    req_i = 1'b0;
    r_lat = 1;
    while (!done_o && r_lat < 12) begin
      @(negedge clk_i);
      r_lat++;
    end
    r_addr = addr_o;
    r_cyc  = cycles_o;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 idle in reset", {31'd0, idle_o}, 32'd1);
    chk("R1 done in reset", {31'd0, done_o}, 32'd0);
    chk("R1 re in reset", {31'd0, mem_re_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", {31'd0, idle_o}, 32'd1);
    chk("R1 done after reset", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_direct;
    run(4'd0, 1'b0, 8'h9C, 8'h77, 8'h01, 8'h02);
    chk("R2 imm addr", r_addr, 16'h009C); chk("R2 imm lat", r_lat, 1);
    chk("R10 imm cyc", r_cyc, 4'd2);
    run(4'd13, 1'b0, 8'h3B, 8'h55, 8'h00, 8'h00);
    chk("R2 reserved addr", r_addr, 16'h003B); chk("R10 reserved cyc", r_cyc, 4'd2);
    run(4'd1, 1'b1, 8'h44, 8'hAA, 8'h10, 8'h10);
    chk("R2 zp addr", r_addr, 16'h0044); chk("R11 zp store cyc", r_cyc, 4'd3);
    run(4'd4, 1'b0, 8'h34, 8'h12, 8'h10, 8'h10);
    chk("R2 abs addr", r_addr, 16'h1234); chk("R10 abs cyc", r_cyc, 4'd4);
    chk("R2 abs lat", r_lat, 1);
  endtask

  task automatic t_zp_index;
    run(4'd2, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h00);
    chk("R3 zpx wrap", r_addr, 16'h0010); chk("R10 zpx cyc", r_cyc, 4'd4);
    run(4'd3, 1'b0, 8'h80, 8'h12, 8'h05, 8'h7F);
    chk("R3 zpy", r_addr, 16'h00FF);
  endtask

  task automatic t_abs_index;
    run(4'd5, 1'b0, 8'hFF, 8'h12, 8'h01, 8'h00);
    chk("R4 absx carry", r_addr, 16'h1300); chk("R10 absx cyc", r_cyc, 4'd4);
    run(4'd6, 1'b1, 8'hF0, 8'hFF, 8'h00, 8'h20);
    chk("R4 absy wrap", r_addr, 16'h0010); chk("R11 absy store cyc", r_cyc, 4'd5);
  endtask

  task automatic t_zind;
    run(4'd7, 1'b0, 8'hFF, 8'h33, 8'h01, 8'h01);
    chk("R5 rd lo", rd_log[r_base % 16], 16'h00FF);
    chk("R5 rd hi wrap", rd_log[(r_base + 1) % 16], 16'h0000);
    chk("R5 addr", r_addr, {memf(16'h0000), memf(16'h00FF)});
    chk("R5 lat", r_lat, 4); chk("R10 zind cyc", r_cyc, 4'd5);
    run(4'd7, 1'b1, 8'h20, 8'h00, 8'h00, 8'h00);
    chk("R11 zind store cyc", r_cyc, 4'd6);
  endtask

  task automatic t_xind;
    run(4'd8, 1'b0, 8'hF0, 8'h00, 8'h15, 8'h00);
    chk("R6 rd lo", rd_log[r_base % 16], 16'h0005);
    chk("R6 rd hi", rd_log[(r_base + 1) % 16], 16'h0006);
    chk("R6 addr", r_addr, {memf(16'h0006), memf(16'h0005)});
    chk("R10 xind cyc", r_cyc, 4'd6);
    run(4'd8, 1'b1, 8'hFE, 8'h00, 8'h01, 8'h00);
    chk("R6 rd hi wrap", rd_log[(r_base + 1) % 16], 16'h0000);
    chk("R11 xind store cyc", r_cyc, 4'd6);
  endtask

  task automatic t_indy;
    logic [15:0] p;
    run(4'd9, 1'b0, 8'h10, 8'h00, 8'h00, 8'hF0);
    p = {memf(16'h0011), memf(16'h0010)};
    chk("R7 addr", r_addr, p + 16'h00F0);
    chk("R7 rd lo", rd_log[r_base % 16], 16'h0010);
    chk("R10 indy cyc", r_cyc, 4'd5);
    run(4'd9, 1'b1, 8'h10, 8'h00, 8'h00, 8'h00);
    chk("R11 indy store cyc", r_cyc, 4'd6);
  endtask

  task automatic t_jind;
    run(4'd10, 1'b0, 8'hFF, 8'h12, 8'h00, 8'h00);
    chk("R8 rd lo", rd_log[r_base % 16], 16'h12FF);
    chk("R8 rd hi page wrap", rd_log[(r_base + 1) % 16], 16'h1200);
    chk("R8 addr", r_addr, {memf(16'h1200), memf(16'h12FF)});
    chk("R10 jind cyc", r_cyc, 4'd5);
  endtask

  task automatic t_jindx;
    run(4'd11, 1'b0, 8'hF0, 8'h12, 8'h0F, 8'h00);
    chk("R9 rd lo", rd_log[r_base % 16], 16'h12FF);
    chk("R9 rd hi page wrap", rd_log[(r_base + 1) % 16], 16'h1200);
    chk("R9 addr", r_addr, {memf(16'h1200), memf(16'h12FF)});
    chk("R10 jindx cyc", r_cyc, 4'd6);
    run(4'd11, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h00);
    chk("R9 carry base", rd_log[r_base % 16], 16'h1310);
    chk("R9 carry hi", rd_log[(r_base + 1) % 16], 16'h1311);
  endtask

  task automatic t_busy;
    int b;
    int early;
    int late;
    @(negedge clk_i);
    b = rd_n;
    req_i = 1'b1; mode_i = 4'd7; store_i = 1'b0; op_lo_i = 8'h40; op_hi_i = 8'h00;
    @(negedge clk_i);
    early = done_o;
    chk("R12 busy", {31'd0, idle_o}, 32'd0);
    mode_i = 4'd4; op_lo_i = 8'h99; op_hi_i = 8'h88;  // request while busy
    @(negedge clk_i);
    req_i = 1'b0;
    early = early | done_o;
    @(negedge clk_i);
    early = early | done_o;
    @(negedge clk_i);
    chk("R12 no early done", early, 0);
    chk("R12 done", {31'd0, done_o}, 32'd1);
    chk("R12 result kept", addr_o, {memf(16'h0041), memf(16'h0040)});
    chk("R12 read kept", rd_log[b % 16], 16'h0040);
    late = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      late = late | done_o | mem_re_o;
    end
    chk("R12 dropped request", late, 0);
    chk("R12 idle again", {31'd0, idle_o}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_zp_index();
    t_abs_index();
    t_zind();
    t_xind();
    t_indy();
    t_jind();
    t_jindx();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule